// File: doc/BRIEF.md
# Set-Associative Paging Translation Cache

This block caches linear-to-physical page translations for a 32-bit paged address space. There are four ways, each with eight sets. The set is chosen by linear address bits 14:12, and the full 20-bit linear page number is kept as the tag. Each entry holds:

- the tag;
- a 20-bit physical frame;
- a valid bit;
- a dirty bit;
- a two-bit permission field, where bit 0 grants write and bit 1 grants user access.

A lookup returns hit, the physical address and a protection-fault flag one clock after it is accepted. A write that finds a clean entry is reported as a miss, so that the page walker fetches the entry again and marks it dirty. After a walk the walker installs the result through the fill port. The victim way is picked by a round-robin counter that each set keeps for itself. Maintenance consists of a whole-cache flush, a single-page invalidate and a diagnostic test port. The test port can search for an entry or write one directly.

The lookup request is a valid/ready stream. `lk_ready` drops in any cycle that a flush, invalidate, fill or test command is presented. A request held with `lk_valid` high simply waits. The result stream has no back-pressure: `res_valid` pulses for exactly one cycle, one clock after each accepted request, and the consumer must take it then. Flush, invalidate, fill and test are single-cycle strobes that are always accepted, in priority order.

Top module: `paging_tlb`

## Requirements
- R1: Timing and hit rule for an accepted lookup.
  - A lookup is accepted when `lk_valid` and `lk_ready` are both high, and its result appears one clock later with `res_valid` high for one cycle.
  - `res_hit` is 1 when some way of the set `lk_addr[14:12]` holds a valid entry whose tag equals `lk_addr[31:12]`, and the access is a read or the entry is dirty.
  - On a hit, `res_paddr` is `{frame, lk_addr[11:0]}`. On a miss, `res_paddr` is 0 and `res_fault` is 0.
- R2: A write access (`lk_mode[0]=1`) that matches a valid but clean entry gives `res_hit=0`.
- R3: User-access protection check.
  - On a hit with `lk_mode[1]=1` (user), a read faults unless the entry permission bit 1 is set.
  - A user write faults unless both permission bits are set.
  - Supervisor reads never fault.
- R4: A supervisor write (`lk_mode=01`) hitting an entry with permission `10` (user, read-only) faults only when `wp_en=1`. Otherwise supervisor writes do not fault.
- R5: Fill placement and contents.
  - A fill writes tag `fill_addr[31:12]`, `fill_frame`, `fill_perm` and valid=1.
  - The dirty bit is set to `fill_write`.
  - The way is the set's own round-robin counter, which then steps 0,1,2,3,0. A fifth fill to one set therefore evicts the first.
- R6: `flush` clears the valid bit of every entry, so every later lookup misses until a refill.
- R7: `inval_valid` clears only a valid entry in set `inval_addr[14:12]` whose tag equals `inval_addr[31:12]`. Other entries keep hitting.
- R8: Test lookup (`test_cmd[0]=1`).
  - The command is `test_cmd[31:12]` as the tag and `test_cmd[1]` as the required valid value; both must match.
  - One clock later `test_done` is high. On a match, `test_data_out` = `{frame, 9'b0, way[1:0], 1'b1}`. The lowest matching way wins.
  - On a match, `test_cmd_out` is `test_cmd` with bits 7:2 replaced by D, not-D, U, not-U, W, not-W (bit 2 = D).
  - On a miss, `test_data_out` is `test_data_in` with bit 0 cleared, and `test_cmd_out` equals `test_cmd`.
- R9: Test write (`test_cmd[0]=0`).
  - The entry is written in set `test_cmd[14:12]` with tag `test_cmd[31:12]`, frame `test_data_in[31:12]`, valid `test_cmd[1]`, dirty `test_cmd[2]`, user `test_cmd[4]` and write `test_cmd[6]`.
  - The way is `test_data_in[2:1]` when `test_data_in[0]=1`. Otherwise the round-robin counter picks the way and advances.
- R10: Reset (`rst_n=0`, synchronous) clears every valid bit, every victim counter, `res_valid` and `test_done`.
- R11: Port priority and exclusion.
  - `lk_ready` is 0 in any cycle where `flush`, `inval_valid`, `fill_valid` or `test_valid` is high.
  - When several of those coincide, only the highest-priority one acts, in the order flush, invalidate, fill, test. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle |
| lk_addr | input | 32 | Linear address to translate |
| lk_mode | input | 2 | Access kind: bit 0 write, bit 1 user |
| wp_en | input | 1 | Supervisor write-protect enable |
| res_valid | output | 1 | Lookup result valid (one-cycle pulse) |
| res_hit | output | 1 | Translation found with adequate dirty state |
| res_paddr | output | 32 | Physical address on hit, else 0 |
| res_fault | output | 1 | Protection violation on a hit |
| fill_valid | input | 1 | Install a walked translation |
| fill_addr | input | 32 | Linear address of the walked page |
| fill_frame | input | 20 | Physical frame number |
| fill_perm | input | 2 | Combined permission: bit 0 write, bit 1 user |
| fill_write | input | 1 | Walk was for a write (sets dirty) |
| flush | input | 1 | Invalidate the whole cache |
| inval_valid | input | 1 | Invalidate one page |
| inval_addr | input | 32 | Linear address of the page to drop |
| test_valid | input | 1 | Execute a test command |
| test_cmd | input | 32 | Test command word |
| test_data_in | input | 32 | Test data word |
| test_done | output | 1 | Test command completed (one-cycle pulse) |
| test_cmd_out | output | 32 | Updated command word |
| test_data_out | output | 32 | Updated data word |

## Verification
A corrupted tag, frame or permission field shows on the very next accepted lookup of that page. It appears one clock after acceptance as a wrong hit, a wrong physical address or a wrong fault. A victim counter that steps badly stays hidden until a fifth fill lands in the same set. At that point the wrong translation survives, and a test lookup reports the wrong way number one clock after the command. A valid bit that a flush or invalidate failed to clear shows as a stale hit on the first lookup afterwards. One that is dropped by mistake shows as a miss on a page that should still hit.

// File: rtl/paging_tlb_pkg.sv
package paging_tlb_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int PG_W  = VA_W - OFF_W;

  // perm[0] = write allowed, perm[1] = user allowed
  typedef struct packed {
    logic            valid;
    logic            dirty;
    logic [1:0]      perm;
    logic [PG_W-1:0] tag;
    logic [PG_W-1:0] frame;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_prot.sv
module tlb_prot (
  input  logic       req_write,
  input  logic       req_user,
  input  logic       wp_en,
  input  logic [1:0] perm,
  output logic       fault
);
  always_comb begin
    if (req_user)
      fault = req_write ? ~(perm[1] & perm[0]) : ~perm[1];
    else
      fault = req_write & wp_en & (perm == 2'b10);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 4,
  localparam int IDX_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [IDX_W-1:0] idx,
  output logic [WAY_W-1:0] way
);
  logic [WAY_W-1:0] cnt_q [NUM_SETS];

  assign way = cnt_q[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) cnt_q[s] <= '0;
    end else if (adv) begin
      cnt_q[idx] <= (cnt_q[idx] == WAY_W'(NUM_WAYS-1)) ? '0 : cnt_q[idx] + 1'b1;
    end
  end

  assert_victim_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> cnt_q[$past(idx)] ==
            (($past(way) == WAY_W'(NUM_WAYS-1)) ? '0 : $past(way) + 1'b1));
endmodule

// File: rtl/tlb_way_store.sv
module tlb_way_store
  import paging_tlb_pkg::*;
#(
  parameter int NUM_SETS = 8,
  localparam int IDX_W = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [PG_W-1:0]  inv_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_ent_t         wr_ent,
  input  logic [IDX_W-1:0] rd_idx,
  output tlb_ent_t         rd_ent
);
  tlb_ent_t ent_q [NUM_SETS];
  logic [NUM_SETS-1:0] vld;

  assign rd_ent = ent_q[rd_idx];

  always_comb
    for (int s = 0; s < NUM_SETS; s++) vld[s] = ent_q[s].valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) ent_q[s] <= '0;
    end else if (clear_all) begin
      for (int s = 0; s < NUM_SETS; s++) ent_q[s].valid <= 1'b0;
    end else if (inv_en) begin
      if (ent_q[inv_idx].valid && ent_q[inv_idx].tag == inv_tag)
        ent_q[inv_idx].valid <= 1'b0;
    end else if (wr_en) begin
      ent_q[wr_idx] <= wr_ent;
    end
  end

  assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> vld == '0);

  assert_inval_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !clear_all) |=>
      (!ent_q[$past(inv_idx)].valid || ent_q[$past(inv_idx)].tag != $past(inv_tag)));
endmodule

// File: rtl/paging_tlb.sv
module paging_tlb
  import paging_tlb_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic [31:0] lk_addr,
  input  logic [1:0]  lk_mode,
  input  logic        wp_en,
  output logic        res_valid,
  output logic        res_hit,
  output logic [31:0] res_paddr,
  output logic        res_fault,
  input  logic        fill_valid,
  input  logic [31:0] fill_addr,
  input  logic [19:0] fill_frame,
  input  logic [1:0]  fill_perm,
  input  logic        fill_write,
  input  logic        flush,
  input  logic        inval_valid,
  input  logic [31:0] inval_addr,
  input  logic        test_valid,
  input  logic [31:0] test_cmd,
  input  logic [31:0] test_data_in,
  output logic        test_done,
  output logic [31:0] test_cmd_out,
  output logic [31:0] test_data_out
);
  localparam int IDX_W = $clog2(NUM_SETS);
  localparam int WAY_W = $clog2(NUM_WAYS);

  // ---------------- operation select ----------------
  logic do_inv, do_fill, do_test, test_lk, test_wr, lk_go;
  assign do_inv   = inval_valid & ~flush;
  assign do_fill  = fill_valid & ~flush & ~inval_valid;
  assign do_test  = test_valid & ~flush & ~inval_valid & ~fill_valid;
  assign test_lk  = do_test & test_cmd[0];
  assign test_wr  = do_test & ~test_cmd[0];
  assign lk_ready = ~(flush | inval_valid | fill_valid | test_valid);
  assign lk_go    = lk_valid & lk_ready;

  logic [IDX_W-1:0] lk_idx, fill_idx, test_idx, inv_idx, rd_idx, vic_idx;
  assign lk_idx   = lk_addr[OFF_W +: IDX_W];
  assign fill_idx = fill_addr[OFF_W +: IDX_W];
  assign test_idx = test_cmd[OFF_W +: IDX_W];
  assign inv_idx  = inval_addr[OFF_W +: IDX_W];
  assign rd_idx   = do_test ? test_idx : lk_idx;
  assign vic_idx  = do_fill ? fill_idx : test_idx;

  // ---------------- victim selection ----------------
  logic             vic_adv, use_given_way;
  logic [WAY_W-1:0] vic_way, wr_way;
  assign use_given_way = test_wr & test_data_in[0];
  assign vic_adv       = do_fill | (test_wr & ~test_data_in[0]);
  assign wr_way        = use_given_way ? test_data_in[WAY_W:1] : vic_way;

  tlb_victim #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .adv(vic_adv), .idx(vic_idx), .way(vic_way)
  );

  // ---------------- write entry ----------------
  tlb_ent_t wr_ent;
  always_comb begin
    if (do_fill) begin
      wr_ent.valid = 1'b1;
      wr_ent.dirty = fill_write;
      wr_ent.perm  = fill_perm;
      wr_ent.tag   = fill_addr[VA_W-1:OFF_W];
      wr_ent.frame = fill_frame;
    end else begin
      wr_ent.valid = test_cmd[1];
      wr_ent.dirty = test_cmd[2];
      wr_ent.perm  = {test_cmd[4], test_cmd[6]};
      wr_ent.tag   = test_cmd[VA_W-1:OFF_W];
      wr_ent.frame = test_data_in[VA_W-1:OFF_W];
    end
  end

  // ---------------- way storage ----------------
  tlb_ent_t rd_ent [NUM_WAYS];
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    tlb_way_store #(.NUM_SETS(NUM_SETS)) u_store (
      .clk(clk), .rst_n(rst_n),
      .clear_all(flush),
      .inv_en(do_inv), .inv_idx(inv_idx), .inv_tag(inval_addr[VA_W-1:OFF_W]),
      .wr_en((do_fill | test_wr) && wr_way == WAY_W'(w)),
      .wr_idx(vic_idx), .wr_ent(wr_ent),
      .rd_idx(rd_idx), .rd_ent(rd_ent[w])
    );
  end

  // ---------------- lookup match ----------------
  logic     lk_hit;
  tlb_ent_t lk_ent;
  always_comb begin
    lk_hit = 1'b0;
    lk_ent = '0;
    for (int w = NUM_WAYS-1; w >= 0; w--) begin
      if (rd_ent[w].valid && rd_ent[w].tag == lk_addr[VA_W-1:OFF_W] &&
          (!lk_mode[0] || rd_ent[w].dirty)) begin
        lk_hit = 1'b1;
        lk_ent = rd_ent[w];
      end
    end
  end

  logic lk_fault;
  tlb_prot u_prot (
    .req_write(lk_mode[0]), .req_user(lk_mode[1]), .wp_en(wp_en),
    .perm(lk_ent.perm), .fault(lk_fault)
  );

  logic       usr_q;
  logic [1:0] perm_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_fault <= 1'b0;
      res_paddr <= '0;
      usr_q     <= 1'b0;
      perm_q    <= '0;
    end else begin
      res_valid <= lk_go;
      res_hit   <= lk_go & lk_hit;
      res_fault <= lk_go & lk_hit & lk_fault;
      res_paddr <= (lk_go & lk_hit) ? {lk_ent.frame, lk_addr[OFF_W-1:0]} : '0;
      usr_q     <= lk_mode[1];
      perm_q    <= lk_ent.perm;
    end
  end

  // ---------------- test lookup ----------------
  logic             t_hit;
  tlb_ent_t         t_ent;
  logic [WAY_W-1:0] t_way;
  always_comb begin
    t_hit = 1'b0;
    t_ent = '0;
    t_way = '0;
    for (int w = NUM_WAYS-1; w >= 0; w--) begin
      if (rd_ent[w].valid == test_cmd[1] && rd_ent[w].tag == test_cmd[VA_W-1:OFF_W]) begin
        t_hit = 1'b1;
        t_ent = rd_ent[w];
        t_way = WAY_W'(w);
      end
    end
  end

  logic [31:0] t_cmd_n, t_data_n;
  always_comb begin
    t_cmd_n  = test_cmd;
    t_data_n = test_data_in;
    if (test_lk) begin
      if (t_hit) begin
        t_data_n                 = '0;
        t_data_n[VA_W-1:OFF_W]   = t_ent.frame;
        t_data_n[WAY_W:1]        = t_way;
        t_data_n[0]              = 1'b1;
        t_cmd_n[7:2] = {~t_ent.perm[0], t_ent.perm[0], ~t_ent.perm[1], t_ent.perm[1],
                        ~t_ent.dirty, t_ent.dirty};
      end else begin
        t_data_n[0] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      test_done     <= 1'b0;
      test_cmd_out  <= '0;
      test_data_out <= '0;
    end else begin
      test_done <= do_test;
      if (do_test) begin
        test_cmd_out  <= t_cmd_n;
        test_data_out <= t_data_n;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_result_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(lk_valid && lk_ready));

  assert_user_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit && usr_q && !perm_q[1]) |-> res_fault);

  assert_miss_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (!res_fault && res_paddr == '0));

  assert_test_reply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_valid && !flush && !inval_valid && !fill_valid) |=> test_done);

  assert_no_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && lk_valid) |=> !res_valid);
endmodule

// File: tb/paging_tlb_bench.sv
`timescale 1ns/1ps
module paging_tlb_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lk_valid = 0, wp_en = 0, fill_valid = 0, fill_write = 0;
  logic        flush = 0, inval_valid = 0, test_valid = 0;
  logic [31:0] lk_addr = 0, fill_addr = 0, inval_addr = 0, test_cmd = 0, test_data_in = 0;
  logic [1:0]  lk_mode = 0, fill_perm = 0;
  logic [19:0] fill_frame = 0;
  logic        lk_ready, res_valid, res_hit, res_fault, test_done;
  logic [31:0] res_paddr, test_cmd_out, test_data_out;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  paging_tlb u_paging_tlb (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_addr(lk_addr), .lk_mode(lk_mode), .wp_en(wp_en),
    .res_valid(res_valid), .res_hit(res_hit), .res_paddr(res_paddr), .res_fault(res_fault),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_frame(fill_frame),
    .fill_perm(fill_perm), .fill_write(fill_write), .flush(flush),
    .inval_valid(inval_valid), .inval_addr(inval_addr), .test_valid(test_valid),
    .test_cmd(test_cmd), .test_data_in(test_data_in), .test_done(test_done),
    .test_cmd_out(test_cmd_out), .test_data_out(test_data_out)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  mode;
    logic        wp;
    logic        hit;
    logic        fault;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_1ABC, 2'b00, 1'b0, 1'b1, 1'b0, 32'hAAAA_AABC}, // R1 sup read
    '{32'h0000_1ABC, 2'b11, 1'b0, 1'b1, 1'b0, 32'hAAAA_AABC}, // R3 user write ok
    '{32'h0000_2010, 2'b00, 1'b0, 1'b1, 1'b0, 32'h1234_5010}, // R1
    '{32'h0000_2010, 2'b01, 1'b0, 1'b0, 1'b0, 32'h0},          // R2 clean write miss
    '{32'h0000_2010, 2'b10, 1'b0, 1'b1, 1'b1, 32'h1234_5010}, // R3 user read no U
    '{32'h0000_3FFF, 2'b10, 1'b0, 1'b1, 1'b0, 32'h0BEE_FFFF}, // R3 user read ok
    '{32'h0000_3FFF, 2'b11, 1'b0, 1'b0, 1'b0, 32'h0},          // R2
    '{32'h0000_4000, 2'b01, 1'b0, 1'b1, 1'b0, 32'h5432_1000}, // R4 sup write
    '{32'h0000_4000, 2'b11, 1'b0, 1'b1, 1'b1, 32'h5432_1000}, // R3 user write no U/W
    '{32'h0000_9000, 2'b00, 1'b0, 1'b0, 1'b0, 32'h0},          // R1 tag mismatch
    '{32'h0000_6000, 2'b00, 1'b0, 1'b0, 1'b0, 32'h0},          // R1 empty set
    '{32'h0000_5004, 2'b01, 1'b0, 1'b1, 1'b0, 32'h0F00_D004}, // R4 wp off
    '{32'h0000_5004, 2'b01, 1'b1, 1'b1, 1'b1, 32'h0F00_D004}, // R4 wp on
    '{32'h0000_5004, 2'b10, 1'b1, 1'b1, 1'b0, 32'h0F00_D004}  // R4 user read
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] a, input logic [1:0] m, input logic wp);
    @(negedge clk);
    lk_valid = 1; lk_addr = a; lk_mode = m; wp_en = wp;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic expect_lk(input string req, input logic [31:0] a, input logic [1:0] m,
                           input logic wp, input logic h, input logic f, input logic [31:0] pa);
    lookup(a, m, wp);
    chk(req, {res_valid, res_hit, res_fault}, {29'b0, 1'b1, h, f});
    chk(req, res_paddr, pa);
  endtask

  task automatic fill(input logic [31:0] a, input logic [19:0] fr, input logic [1:0] p,
                      input logic w);
    @(negedge clk);
    fill_valid = 1; fill_addr = a; fill_frame = fr; fill_perm = p; fill_write = w;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic test_op(input logic [31:0] c, input logic [31:0] d);
    @(negedge clk);
    test_valid = 1; test_cmd = c; test_data_in = d;
    @(negedge clk);
    test_valid = 0;
  endtask

  task automatic expect_test(input string req, input logic [31:0] c, input logic [31:0] d,
                             input logic [31:0] ec, input logic [31:0] ed);
    test_op(c, d);
    chk(req, {31'b0, test_done}, 32'h1);
    chk(req, test_cmd_out, ec);
    chk(req, test_data_out, ed);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", {29'b0, res_valid, test_done, lk_ready}, 32'h1);
    rst_n = 1;
    expect_lk("R10", 32'h0000_1000, 2'b00, 0, 0, 0, 32'h0);

    // setup fills, each first in its set -> way 0
    fill(32'h0000_1000, 20'hAAAAA, 2'b11, 1);
    fill(32'h0000_2000, 20'h12345, 2'b01, 0);
    fill(32'h0000_3000, 20'h0BEEF, 2'b10, 0);
    fill(32'h0000_4000, 20'h54321, 2'b00, 1);
    fill(32'h0000_5000, 20'h0F00D, 2'b10, 1);

    for (int i = 0; i < NV; i++)
      expect_lk($sformatf("R1-R4 vector %0d", i), VEC[i].addr, VEC[i].mode, VEC[i].wp,
                VEC[i].hit, VEC[i].fault, VEC[i].pa);

    // R5 dirty from write fill, reported via test lookup (R8)
    expect_test("R5", 32'h0000_1003, 32'h0, 32'h0000_1057, 32'hAAAA_A001);

    // R5 round robin in set 7: fifth fill evicts the first
    for (int k = 0; k < 5; k++)
      fill(32'h0000_7000 + 32'(k) * 32'h8000, 20'h10000 + 20'(k), 2'b11, 0);
    expect_lk("R5", 32'h0000_7000, 2'b00, 0, 0, 0, 32'h0);
    expect_lk("R5", 32'h0000_F000, 2'b00, 0, 1, 0, 32'h1000_1000);
    expect_test("R5", 32'h0002_7003, 32'h0, 32'h0002_705B, 32'h1000_4001);
    expect_test("R8", 32'h0001_F003, 32'h0, 32'h0001_F05B, 32'h1000_3007);

    // R8 test lookup miss clears hit flag, command unchanged
    expect_test("R8", 32'h0009_9003, 32'hFFFF_FFFF, 32'h0009_9003, 32'hFFFF_FFFE);

    // R7 invalidate
    @(negedge clk); inval_valid = 1; inval_addr = 32'h0000_1234;
    @(negedge clk); inval_valid = 0;
    @(negedge clk); inval_valid = 1; inval_addr = 32'h0000_B000;
    @(negedge clk); inval_valid = 0;
    expect_lk("R7", 32'h0000_1ABC, 2'b00, 0, 0, 0, 32'h0);
    expect_lk("R7", 32'h0000_2010, 2'b00, 0, 1, 0, 32'h1234_5010);
    expect_lk("R7", 32'h0000_3FFF, 2'b10, 0, 1, 0, 32'h0BEE_FFFF);
    // R8 lookup with required valid = 0 finds the invalidated entry
    expect_test("R8", 32'h0000_1001, 32'h0, 32'h0000_1055, 32'hAAAA_A001);

    // R9 test write with explicit way 2
    expect_test("R9", 32'h0000_6016, 32'h7777_7005, 32'h0000_6016, 32'h7777_7005);
    expect_lk("R9", 32'h0000_6123, 2'b10, 0, 1, 0, 32'h7777_7123);
    expect_lk("R9", 32'h0000_6123, 2'b11, 0, 1, 1, 32'h7777_7123);
    expect_test("R9", 32'h0000_6003, 32'h0, 32'h0000_6097, 32'h7777_7005);
    // R9 test write using round-robin: ways 0 then 1
    test_op(32'h0000_E002, 32'h3333_3000);
    test_op(32'h0001_6002, 32'h4444_4000);
    expect_test("R9", 32'h0000_E003, 32'h0, 32'h0000_E0AB, 32'h3333_3001);
    expect_test("R9", 32'h0001_6003, 32'h0, 32'h0001_60AB, 32'h4444_4003);

    // R11 lk_ready low during fill; flush beats a same-cycle fill (R6)
    @(negedge clk);
    fill_valid = 1; fill_addr = 32'h0000_A000; fill_frame = 20'h99999;
    fill_perm = 2'b11; fill_write = 0; flush = 1; lk_valid = 1; lk_addr = 32'h0000_2010;
    #1 chk("R11", {31'b0, lk_ready}, 32'h0);
    @(negedge clk);
    fill_valid = 0; flush = 0; lk_valid = 0;
    chk("R11", {31'b0, res_valid}, 32'h0);
    expect_lk("R11", 32'h0000_A000, 2'b00, 0, 0, 0, 32'h0);
    expect_lk("R6", 32'h0000_2010, 2'b00, 0, 0, 0, 32'h0);
    expect_lk("R6", 32'h0000_6123, 2'b10, 0, 0, 0, 32'h0);

    // R10 reset mid-run clears victim counters
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    test_op(32'h0000_E002, 32'h5555_5000);
    expect_test("R10", 32'h0000_E003, 32'h0, 32'h0000_E0AB, 32'h5555_5001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule